// File: doc/BRIEF.md
# Command Buffer Control State Machine

This block is the device-side control logic behind a command-response-buffer register interface. Four small registers sit behind a plain write/read port. The request register holds two bits that software sets: one asks for the ready state and one asks for the idle state. The status register reports whether the device is idle and whether a fatal error is present. The start and cancel registers are write-one-to-act fields that launch and abort a command. The block moves through four states: Idle, Ready, Command Execution and Command Completion.

A request bit stays set until the block carries it out. The block then clears the bit, and that is the acknowledgement software waits for. An abstract command engine receives a one-cycle start pulse and a one-cycle cancel pulse, and it answers with a done pulse. The block ends Command Execution only when that done pulse arrives, so any request written meanwhile waits. A request that waits too long sets a sticky timeout flag. The limit is a parameter counted in clock cycles.

There is no data stream in this block. All pins are plain control and status signals that act in the cycle they are seen. There is no back-pressure.

Top module: `crb_ctrl`

## Requirements
- R1: Selector codes on the register port are 0 for request, 1 for status, 2 for start and 3 for cancel. Writing request bit 0 as 1 posts a ready request. The posted request acts on the next clock edge, unless a go-idle request is also pending. In Idle or Command Completion it moves the state to Ready and clears the bit. In Ready it only clears the bit. In Command Execution it is held pending.
- R2: Writing request bit 1 as 1 posts a go-idle request, which acts on the next clock edge. In Ready or Command Completion it moves the state to Idle and clears the bit. In Idle it only clears the bit. In Command Execution it is held pending. It takes priority over a pending ready request.
- R3: Status bit 1 reads 1 exactly while the state is Idle. Status bit 0 reads the fatal input as registered on the previous clock edge.
- R4: Writing 0 to a request bit does not clear it or change it.
- R5: Writing start bit 0 as 1 while in Ready, with no go-idle request pending, enters Command Execution on that edge. Start then reads 1, and eng_start is high for exactly the one following cycle.
- R6: A done pulse in Command Execution moves the state to Command Completion and clears start to 0 on that edge.
- R7: Writing cancel bit 0 as 1 in Command Execution, in a cycle without done, sets cancel to 1 and gives a one-cycle eng_cancel pulse. Writing 1 in any other state is ignored. Writing 0 clears cancel in any state.
- R8: A start write in any state other than Ready is ignored, and so is a start write with bit 0 equal to 0. Neither changes the state or the start register.
- R9: When any request bit has been pending for TO_CYCLES consecutive cycles, timeout_o rises and stays high until reset.
- R10: After reset the state is Idle. state_o uses the codes 0 for Idle, 1 for Ready, 2 for Command Execution and 3 for Command Completion. Status reads 2. Request, start and cancel read 0. Both engine pulses and timeout_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register selector for the write |
| wr_data | input | DATA_W | Write data |
| rd_sel | input | 2 | Register selector for the read |
| rd_data | output | DATA_W | Read data of the selected register, combinational |
| eng_done | input | 1 | Engine reports that the command has finished |
| fatal_in | input | 1 | Fatal error indication from the engine |
| eng_start | output | 1 | One-cycle pulse that launches a command |
| eng_cancel | output | 1 | One-cycle pulse that aborts the running command |
| state_o | output | 2 | Current control state |
| timeout_o | output | 1 | Sticky flag: a request waited too long |

## Verification
The hardest case to reach is the timeout. Every request is served within one cycle in every state except Command Execution, so the flag can only rise while a request waits on an engine that stays silent. The directed phase gets there in four steps: it requests Ready, starts a command, posts a go-idle request and then holds eng_done low for longer than the limit. It then cancels the command and lets it complete, which shows that the flag stays set once the request is served. A random phase follows, with rare done pulses. It covers request collisions, cancels outside Execution and start writes in the wrong state, and a behavioural model checks it on every clock.

// File: rtl/crb_pkg.sv
package crb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READY = 2'd1,
    ST_EXEC  = 2'd2,
    ST_COMPL = 2'd3
  } crb_state_e;

  localparam logic [1:0] SEL_REQ    = 2'd0;
  localparam logic [1:0] SEL_STAT   = 2'd1;
  localparam logic [1:0] SEL_START  = 2'd2;
  localparam logic [1:0] SEL_CANCEL = 2'd3;

  // request register bit positions (also index into the request flop array)
  localparam int REQ_N     = 2;
  localparam int B_CMDRDY  = 0;
  localparam int B_GOIDLE  = 1;
  // status register bit positions
  localparam int B_FATAL   = 0;
  localparam int B_IDLE    = 1;
  // start / cancel action bit
  localparam int B_ACT     = 0;
endpackage

// File: rtl/crb_req_regs.sv
module crb_req_regs #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] q_o
);
  // software sets, control logic acknowledges by clearing; a new set wins
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         q_o[g] <= 1'b0;
      else if (set_i[g])  q_o[g] <= 1'b1;
      else if (clr_i[g])  q_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/crb_timeout.sv
module crb_timeout #(
  parameter int TO_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pend_i,
  output logic flag_o
);
  localparam int CNT_W = $clog2(TO_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TO_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_o <= 1'b0;
    end else begin
      if (!pend_i)            cnt_q <= '0;
      else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
      if (pend_i && cnt_q == LAST) flag_o <= 1'b1;
    end
  end
endmodule

// File: rtl/crb_fsm.sv
module crb_fsm
  import crb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rdy_req_i,
  input  logic       idle_req_i,
  input  logic       start_wr_i,
  input  logic       cancel_set_i,
  input  logic       cancel_clr_i,
  input  logic       eng_done_i,
  output crb_state_e state_o,
  output logic       clr_rdy_o,
  output logic       clr_idle_o,
  output logic       start_q_o,
  output logic       cancel_q_o,
  output logic       eng_start_o,
  output logic       eng_cancel_o
);
  crb_state_e state_d;
  logic start_d, cancel_d, go_d, abort_d;

  always_comb begin
    state_d    = state_o;
    clr_rdy_o  = 1'b0;
    clr_idle_o = 1'b0;
    start_d    = start_q_o;
    cancel_d   = cancel_q_o;
    go_d       = 1'b0;
    abort_d    = 1'b0;
    unique case (state_o)
      ST_IDLE: begin
        if (idle_req_i)     clr_idle_o = 1'b1;
        else if (rdy_req_i) begin clr_rdy_o = 1'b1; state_d = ST_READY; end
      end
      ST_READY: begin
        if (idle_req_i) begin
          clr_idle_o = 1'b1;
          state_d    = ST_IDLE;
        end else begin
          if (rdy_req_i) clr_rdy_o = 1'b1;
          if (start_wr_i) begin
            state_d = ST_EXEC;
            start_d = 1'b1;
            go_d    = 1'b1;
          end
        end
      end
      ST_EXEC: begin
        if (eng_done_i) begin
          state_d = ST_COMPL;
          start_d = 1'b0;
        end else if (cancel_set_i) begin
          cancel_d = 1'b1;
          abort_d  = 1'b1;
        end
      end
      ST_COMPL: begin
        if (idle_req_i)     begin clr_idle_o = 1'b1; state_d = ST_IDLE;  end
        else if (rdy_req_i) begin clr_rdy_o  = 1'b1; state_d = ST_READY; end
      end
      default: state_d = ST_IDLE;
    endcase
    if (cancel_clr_i) cancel_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_o      <= ST_IDLE;
      start_q_o    <= 1'b0;
      cancel_q_o   <= 1'b0;
      eng_start_o  <= 1'b0;
      eng_cancel_o <= 1'b0;
    end else begin
      state_o      <= state_d;
      start_q_o    <= start_d;
      cancel_q_o   <= cancel_d;
      eng_start_o  <= go_d;
      eng_cancel_o <= abort_d;
    end
  end
endmodule

// File: rtl/crb_ctrl.sv
module crb_ctrl
  import crb_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int TO_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  input  logic              eng_done,
  input  logic              fatal_in,
  output logic              eng_start,
  output logic              eng_cancel,
  output logic [1:0]        state_o,
  output logic              timeout_o
);
  localparam int PAD_W = DATA_W - 2;

  logic [REQ_N-1:0] req_set, req_clr, req_q;
  logic             start_q, cancel_q, fatal_q;
  crb_state_e       state;
  logic             unused_wr_hi;

  assign unused_wr_hi = ^wr_data[DATA_W-1:2];

  // request bits are only ever set by software
  always_comb begin
    req_set = '0;
    if (wr_en && wr_sel == SEL_REQ) req_set = wr_data[REQ_N-1:0];
  end

  crb_req_regs #(.N(REQ_N)) u_req (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (req_set),
    .clr_i (req_clr),
    .q_o   (req_q)
  );

  crb_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .rdy_req_i    (req_q[B_CMDRDY]),
    .idle_req_i   (req_q[B_GOIDLE]),
    .start_wr_i   (wr_en && wr_sel == SEL_START && wr_data[B_ACT]),
    .cancel_set_i (wr_en && wr_sel == SEL_CANCEL && wr_data[B_ACT]),
    .cancel_clr_i (wr_en && wr_sel == SEL_CANCEL && !wr_data[B_ACT]),
    .eng_done_i   (eng_done),
    .state_o      (state),
    .clr_rdy_o    (req_clr[B_CMDRDY]),
    .clr_idle_o   (req_clr[B_GOIDLE]),
    .start_q_o    (start_q),
    .cancel_q_o   (cancel_q),
    .eng_start_o  (eng_start),
    .eng_cancel_o (eng_cancel)
  );

  crb_timeout #(.TO_CYCLES(TO_CYCLES)) u_to (
    .clk    (clk),
    .rst_n  (rst_n),
    .pend_i (|req_q),
    .flag_o (timeout_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fatal_q <= 1'b0;
    else        fatal_q <= fatal_in;
  end

  assign state_o = state;

  always_comb begin
    unique case (rd_sel)
      SEL_REQ:    rd_data = {{PAD_W{1'b0}}, req_q};
      SEL_STAT:   rd_data = {{PAD_W{1'b0}}, (state == ST_IDLE), fatal_q};
      SEL_START:  rd_data = {{PAD_W{1'b0}}, 1'b0, start_q};
      default:    rd_data = {{PAD_W{1'b0}}, 1'b0, cancel_q};
    endcase
  end
endmodule

// File: rtl/crb_ctrl_chk.sv
module crb_ctrl_chk
  import crb_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] state_o,
  input logic       eng_start,
  input logic       eng_cancel,
  input logic       eng_done,
  input logic       timeout_o,
  input logic       start_q,
  input logic [1:0] req_q
);
  a_r5_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> (state_o == ST_EXEC) && start_q);

  a_r6_done_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_EXEC) && eng_done |=> (state_o == ST_COMPL) && !start_q);

  a_r8_start_only_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_q) |-> $past(state_o) == ST_READY);

  a_r2_go_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_q[B_GOIDLE] && (state_o == ST_READY || state_o == ST_COMPL) |=> state_o == ST_IDLE);

  a_r1_ready_entry: assert property (@(posedge clk) disable iff (!rst_n)
    req_q[B_CMDRDY] && !req_q[B_GOIDLE] && state_o == ST_IDLE |=> state_o == ST_READY);

  a_r7_cancel_in_exec: assert property (@(posedge clk) disable iff (!rst_n)
    eng_cancel |-> $past(state_o) == ST_EXEC);

  a_r9_timeout_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> timeout_o);
endmodule

bind crb_ctrl crb_ctrl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .state_o    (state_o),
  .eng_start  (eng_start),
  .eng_cancel (eng_cancel),
  .eng_done   (eng_done),
  .timeout_o  (timeout_o),
  .start_q    (start_q),
  .req_q      (req_q)
);

// File: tb/crb_ctrl_test.sv
`timescale 1ns/1ps
module crb_ctrl_test;
  localparam int DW = 32;
  localparam int TO = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_sel = '0;
  logic [DW-1:0] wr_data = '0;
  logic [1:0]    rd_sel = '0;
  logic [DW-1:0] rd_data;
  logic          eng_done = 1'b0;
  logic          fatal_in = 1'b0;
  logic          eng_start, eng_cancel, timeout_o;
  logic [1:0]    state_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  crb_ctrl #(.DATA_W(DW), .TO_CYCLES(TO)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .eng_done(eng_done), .fatal_in(fatal_in),
    .eng_start(eng_start), .eng_cancel(eng_cancel), .state_o(state_o), .timeout_o(timeout_o)
  );

  // ---------------- behavioural reference ----------------
  int m_state, m_cnt;
  bit m_rr, m_ri, m_start, m_can, m_es, m_ec, m_to, m_fat;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0;
      m_rr = 0; m_ri = 0; m_start = 0; m_can = 0; m_es = 0; m_ec = 0; m_to = 0; m_fat = 0;
    end else begin
      int  ns;
      bit  crr, cri, nst, ncan, nes, nec, pend, srr, sri;
      bit  wstart, wcan1, wcan0;
      ns = m_state; crr = 0; cri = 0; nst = m_start; ncan = m_can; nes = 0; nec = 0;
      wstart = wr_en && wr_sel == 2 && wr_data[0];
      wcan1  = wr_en && wr_sel == 3 && wr_data[0];
      wcan0  = wr_en && wr_sel == 3 && !wr_data[0];
      srr    = wr_en && wr_sel == 0 && wr_data[0];
      sri    = wr_en && wr_sel == 0 && wr_data[1];
      if (m_state == 0) begin
        if (m_ri) cri = 1;
        else if (m_rr) begin crr = 1; ns = 1; end
      end else if (m_state == 1) begin
        if (m_ri) begin cri = 1; ns = 0; end
        else begin
          if (m_rr) crr = 1;
          if (wstart) begin ns = 2; nst = 1; nes = 1; end
        end
      end else if (m_state == 2) begin
        if (eng_done) begin ns = 3; nst = 0; end
        else if (wcan1) begin ncan = 1; nec = 1; end
      end else begin
        if (m_ri) begin cri = 1; ns = 0; end
        else if (m_rr) begin crr = 1; ns = 1; end
      end
      if (wcan0) ncan = 0;
      pend = m_rr | m_ri;
      if (pend && m_cnt == TO - 1) m_to = 1;
      if (!pend) m_cnt = 0;
      else if (m_cnt != TO - 1) m_cnt = m_cnt + 1;
      m_rr = srr | (m_rr & ~crr);
      m_ri = sri | (m_ri & ~cri);
      m_state = ns; m_start = nst; m_can = ncan; m_es = nes; m_ec = nec;
      m_fat = fatal_in;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    longint exp_rd;
    case (rd_sel)
      2'd0: exp_rd = {m_ri, m_rr};
      2'd1: exp_rd = {(m_state == 0), m_fat};
      2'd2: exp_rd = m_start;
      default: exp_rd = m_can;
    endcase
    if (rd_sel == 0)      chk("R1 request read", rd_data, exp_rd);
    else if (rd_sel == 1) chk("R3 status read", rd_data, exp_rd);
    else if (rd_sel == 2) chk("R5 start read", rd_data, exp_rd);
    else                  chk("R7 cancel read", rd_data, exp_rd);
    chk("R2 state", state_o, m_state);
    chk("R5 eng_start", eng_start, m_es);
    chk("R7 eng_cancel", eng_cancel, m_ec);
    chk("R9 timeout", timeout_o, m_to);
  end

  // ---------------- stimulus ----------------
  task automatic step(input bit we, input logic [1:0] sel, input logic [1:0] d, input bit done);
    @(posedge clk); #1;
    wr_en = we; wr_sel = sel; wr_data = {{(DW-2){1'b0}}, d}; eng_done = done;
  endtask

  task automatic idle_n(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  task automatic rd_chk(input logic [1:0] s, input string req, input longint exp);
    @(posedge clk); #1;
    wr_en = 0; eng_done = 0; rd_sel = s;
    @(negedge clk);
    chk(req, rd_data, exp);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R10 reset values
    rd_chk(0, "R10 request after reset", 0);
    rd_chk(1, "R10 status after reset", 2);
    rd_chk(2, "R10 start after reset", 0);
    rd_chk(3, "R10 cancel after reset", 0);
    chk("R10 state after reset", state_o, 0);
    // R8 start write in Idle ignored
    step(1, 2, 1, 0); idle_n(1);
    rd_chk(2, "R8 start ignored in Idle", 0);
    chk("R8 state unchanged", state_o, 0);
    // R4 write of zero to request has no effect
    step(1, 0, 0, 0); idle_n(1);
    rd_chk(0, "R4 zero write to request", 0);
    // R1 ready request
    step(1, 0, 1, 0); idle_n(2);
    chk("R1 state Ready", state_o, 1);
    rd_chk(0, "R1 request acknowledged", 0);
    rd_chk(1, "R3 idle bit clear in Ready", 0);
    // R8 start write with zero ignored in Ready
    step(1, 2, 0, 0); idle_n(1);
    chk("R8 zero start ignored", state_o, 1);
    // R5 start
    step(1, 2, 1, 0); idle_n(1);
    chk("R5 state Exec", state_o, 2);
    rd_chk(2, "R5 start reads 1", 1);
    // R9 go-idle held in Exec beyond limit
    step(1, 0, 2, 0); idle_n(TO + 3);
    chk("R9 timeout raised", timeout_o, 1);
    rd_chk(0, "R2 go-idle held in Exec", 2);
    // R7 cancel
    step(1, 3, 1, 0); idle_n(1);
    rd_chk(3, "R7 cancel set", 1);
    // R6 done
    step(0, 0, 0, 1); step(0, 0, 0, 0);
    @(negedge clk);
    chk("R6 state Completion", state_o, 3);
    idle_n(2);
    chk("R2 back to Idle", state_o, 0);
    rd_chk(2, "R6 start cleared", 0);
    step(1, 3, 0, 0); idle_n(1);
    rd_chk(3, "R7 cancel cleared by zero", 0);
    chk("R9 timeout sticky", timeout_o, 1);
    // R7 cancel write in Idle ignored
    step(1, 3, 1, 0); idle_n(1);
    rd_chk(3, "R7 cancel ignored outside Exec", 0);
    // R3 fatal
    @(posedge clk); #1 fatal_in = 1'b1;
    rd_chk(1, "R3 fatal reported", 3);
    @(posedge clk); #1 fatal_in = 1'b0;
    // random phase with a fresh reset
    @(posedge clk); #1 rst_n = 1'b0;
    @(posedge clk); #1 rst_n = 1'b1;
    for (int i = 0; i < 6000; i++) begin
      @(posedge clk); #1;
      wr_en    = ($urandom_range(0, 2) == 0);
      wr_sel   = 2'($urandom_range(0, 3));
      wr_data  = {{(DW-2){1'b0}}, 2'($urandom_range(0, 3))};
      eng_done = ($urandom_range(0, 19) == 0);
      fatal_in = ($urandom_range(0, 49) == 0);
      rd_sel   = 2'($urandom_range(0, 3));
      if (i == 3000) rst_n = 1'b0;
      if (i == 3002) rst_n = 1'b1;
    end
    @(posedge clk); #1 wr_en = 0; eng_done = 0;
    @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule